// File: doc/BRIEF.md
# Receive Frame Memory Writer

This block stores received Ethernet frames in a shared packet memory, one frame after another. The frame arrives as a stream of 32-bit words, with flags for the last word, the count of valid bytes in that word, an error indication and an out-of-band trailer indication. For each frame the block writes the payload words first. It then writes one header word at the frame's base address, which reserves one word for the header. The header says whether the frame is valid or in error, whether a trailer is present, and how long the frame is.

The host programs a start address and a space budget counted in 32-bit words, then sets the enable bit. After each stored frame the block advances its write address past the header and payload, lowers the budget, sets a ready status bit and pulses a receive interrupt request. If a frame would exceed the budget, the block stops writing and sets a full status bit. It then discards all input until the host rewrites the control register. The host can read back the current write address and compare it with its own read pointer to find pending frames.

Top module: `rx_dma_writer`

## Requirements
- R1: After reset the enable, full and ready bits read as 0, the write address and budget read as 0, `in_ready` is 1, and neither `mem_we` nor `irq_rx` is asserted.
- R2: A word of an accepted frame is written in the same cycle it is accepted. The k-th word of a frame (k from 0) goes to base + 4 + 4k.
- R3: The header is written to the frame base in the cycle after the last word is accepted. In that cycle `irq_rx` is high for exactly one cycle and `in_ready` is low.
- R4: A good frame's header has bit 31 = 1 and bit 30 = 0. Bit 29 copies `in_oob` of the last word. Bits 28:16 are 0. With byte count B, bits 15:0 hold B when B is even and (B+1) with bit 0 set when B is odd. B is 4 per word, except the last word, which counts `in_nbytes` bytes (0 meaning 4).
- R5: After a good frame of N words, the write address grows by 4(N+1) and the budget (register 2) drops by N+1.
- R6: A frame whose last word carries `in_err` gets the header 0xC0000000. The address then grows by 4 and the budget drops by 1, so its payload area is reused.
- R7: A word at frame word index k with k+2 greater than the budget is not written. It sets the full bit (control bit 9). The rest of that frame and all later frames are then dropped: no write, no interrupt, and no change of address or budget.
- R8: With the enable bit (control bit 10) clear, arriving frames are dropped without any write or interrupt. A frame whose first word arrived while disabled is dropped to its end, even if the block is enabled in the middle of it.
- R9: A write to register 0 loads the enable bit from data bit 10 and clears the full and ready bits. Register 0 reads enable at bit 10, full at bit 9 and ready at bit 8, with all other bits 0.
- R10: A write to register 1 sets the write address (low two bits forced to 0), and reading register 1 returns it. Register 2 is the budget in words and is likewise writable and readable. Register 3 reads 0.
- R11: The ready bit (control bit 8) is set in the cycle after each header is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame word present |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_nbytes | input | 2 | Valid bytes in the last word (0 = 4) |
| in_err | input | 1 | Frame ended in error (with last) |
| in_oob | input | 1 | Trailer present (with last) |
| in_ready | output | 1 | Word accepted this cycle when high |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the memory write |
| mem_wdata | output | 32 | Memory write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 address, 2 budget |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_rx | output | 1 | Receive interrupt request pulse |

## Verification
Payload writes appear in the same cycle their word is accepted. The header and the interrupt pulse come one cycle after the last accepted word. The new address, budget and ready bit are visible in register reads from the cycle after the header. The bench drives inputs just after each rising edge. At every falling edge it compares all outputs with a reference model and then steps the model, so each expectation lines up with the cycle the design is due to produce it. Directed checks of header words and register values are made two cycles after the frame's last word, once both of these delays have passed.

// File: rtl/rx_dma_writer.sv
module rx_dma_writer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic          in_last,
  input  logic [1:0]    in_nbytes,
  input  logic          in_err,
  input  logic          in_oob,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_rx
);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_ADR = 2'd1;
  localparam logic [1:0] SEL_AVL = 2'd2;
  localparam int BIT_EN = 10;
  localparam int BIT_FULL = 9;
  localparam int BIT_RDY = 8;

  logic          en_q, full_q, ready_q, drop_q, hdr_q;
  logic [AW-1:0] wr_q, avail_q, cnt_q, hdr_words_q;
  logic [31:0]   hdr_word_q;
  logic          beat, acc, ovf, take;
  logic [AW:0]   need;
  logic [AW+1:0] bytes_total;
  logic [15:0]   blen, beven;

  assign in_ready = !hdr_q;
  assign beat = in_valid && in_ready;
  assign acc = beat && en_q && !full_q && !drop_q;
  assign need = {1'b0, cnt_q} + (AW+1)'(2);
  assign ovf = acc && (need > {1'b0, avail_q});
  assign take = acc && !ovf;

  assign bytes_total = (AW+2)'(cnt_q) * (AW+2)'(4)
                     + ((in_nbytes == 2'd0) ? (AW+2)'(4) : (AW+2)'(in_nbytes));
  assign blen = 16'(bytes_total);
  assign beven = blen + {15'd0, blen[0]};

  assign mem_we = hdr_q || take;
  assign mem_addr = hdr_q ? wr_q : wr_q + AW'(4) + (cnt_q << 2);
  assign mem_wdata = hdr_q ? hdr_word_q : in_data;
  assign irq_rx = hdr_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTL: begin
        reg_rdata[BIT_EN] = en_q;
        reg_rdata[BIT_FULL] = full_q;
        reg_rdata[BIT_RDY] = ready_q;
      end
      SEL_ADR: reg_rdata = 32'(wr_q);
      SEL_AVL: reg_rdata = 32'(avail_q);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      full_q <= 1'b0;
      ready_q <= 1'b0;
      drop_q <= 1'b0;
      hdr_q <= 1'b0;
      wr_q <= '0;
      avail_q <= '0;
      cnt_q <= '0;
      hdr_words_q <= '0;
      hdr_word_q <= '0;
    end else begin
      if (hdr_q) begin
        wr_q <= wr_q + (hdr_words_q << 2);
        avail_q <= avail_q - hdr_words_q;
        ready_q <= 1'b1;
        hdr_q <= 1'b0;
      end
      if (beat && !acc)
        drop_q <= !in_last;
      if (ovf) begin
        full_q <= 1'b1;
        drop_q <= !in_last;
        cnt_q <= '0;
      end
      if (take) begin
        if (in_last) begin
          hdr_q <= 1'b1;
          cnt_q <= '0;
          hdr_words_q <= in_err ? AW'(1) : cnt_q + AW'(2);
          hdr_word_q <= in_err ? 32'hC000_0000
                               : {2'b10, in_oob, 13'd0, beven[15:1], blen[0]};
        end else begin
          cnt_q <= cnt_q + AW'(1);
        end
      end
      if (reg_we) begin
        case (reg_addr)
          SEL_CTL: begin
            en_q <= reg_wdata[BIT_EN];
            full_q <= 1'b0;
            ready_q <= 1'b0;
            cnt_q <= '0;
          end
          SEL_ADR: wr_q <= {reg_wdata[AW-1:2], 2'b00};
          SEL_AVL: avail_q <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_dma_writer_checker.sv
module rx_dma_writer_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_rx,
  input logic          in_ready,
  input logic          mem_we,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          full_q,
  input logic          ready_q,
  input logic [AW-1:0] avail_q
);
  a_r3_header_stalls_input: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> !in_ready);

  a_r3_irq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);

  a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !mem_we);

  a_r9_ctl_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> (!full_q && !ready_q));

  a_r11_ready_after_header: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && !reg_we) |=> ready_q);

  a_r5_budget_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && !reg_we) |=> (avail_q != {AW{1'b1}}) || ($past(avail_q) == {AW{1'b1}}));
endmodule

bind rx_dma_writer rx_dma_writer_checker #(.AW(AW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .irq_rx(irq_rx),
  .in_ready(in_ready),
  .mem_we(mem_we),
  .reg_we(reg_we),
  .reg_addr(reg_addr),
  .full_q(full_q),
  .ready_q(ready_q),
  .avail_q(avail_q)
);

// File: tb/rx_dma_writer_tb.sv
module rx_dma_writer_tb;
  localparam int AW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_last = 1'b0;
  logic [1:0]    in_nbytes = '0;
  logic          in_err = 1'b0;
  logic          in_oob = 1'b0;
  logic          in_ready;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_rx;

  int n_checks = 0;
  int n_err = 0;
  int n_writes = 0;
  int n_irqs = 0;
  logic [31:0] last_hdr = '0;
  bit done = 1'b0;

  rx_dma_writer #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_nbytes(in_nbytes), .in_err(in_err), .in_oob(in_oob),
    .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rx(irq_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, state for the current cycle
  int m_en, m_full, m_ready, m_drop, m_hdr, m_cnt, m_bytes, m_hw;
  int unsigned m_waddr, m_avail, m_hword;

  function automatic int unsigned enc_len(int b);
    return (b % 2 == 1) ? ((b + 1) | 1) : b;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_full = 0; m_ready = 0; m_drop = 0; m_hdr = 0;
      m_cnt = 0; m_bytes = 0; m_hw = 0; m_waddr = 0; m_avail = 0; m_hword = 0;
    end else begin
      bit beat, acc, ovf, take;
      int nb;
      string wtag;
      logic [31:0] exp_rd;
      beat = in_valid && (m_hdr == 0);
      acc = beat && m_en != 0 && m_full == 0 && m_drop == 0;
      ovf = acc && (m_cnt + 2 > int'(m_avail));
      take = acc && !ovf;
      nb = (in_nbytes == 0) ? 4 : int'(in_nbytes);

      chk("R3 in_ready", 32'(in_ready), 32'(m_hdr == 0));
      chk("R3 irq_rx", 32'(irq_rx), 32'(m_hdr));
      if (m_hdr != 0) wtag = "R3";
      else if (beat && m_en == 0) wtag = "R8";
      else if (m_full != 0 || ovf) wtag = "R7";
      else wtag = "R2";
      chk({wtag, " mem_we"}, 32'(mem_we), 32'(m_hdr != 0 || take));
      if (m_hdr != 0) begin
        chk("R3 header address", 32'(mem_addr), m_waddr & 32'hFFFF);
        chk((m_hword[30]) ? "R6 header word" : "R4 header word", mem_wdata, m_hword);
      end else if (take) begin
        chk("R2 payload address", 32'(mem_addr), (m_waddr + 4 + 4 * m_cnt) & 32'hFFFF);
        chk("R2 payload data", mem_wdata, in_data);
      end
      case (reg_addr)
        2'd0: exp_rd = 32'((m_en << 10) | (m_full << 9) | (m_ready << 8));
        2'd1: exp_rd = m_waddr;
        2'd2: exp_rd = m_avail;
        default: exp_rd = 0;
      endcase
      chk((reg_addr == 0) ? "R9 control readback" :
          (reg_addr == 2) ? "R5 budget readback" : "R10 readback", reg_rdata, exp_rd);

      if (mem_we) n_writes++;
      if (irq_rx) begin n_irqs++; last_hdr = mem_wdata; end

      if (m_hdr != 0) begin
        m_waddr = m_waddr + 4 * m_hw;
        m_avail = m_avail - m_hw;
        m_ready = 1;
        m_hdr = 0;
      end
      if (beat && !acc) m_drop = !in_last;
      if (ovf) begin
        m_full = 1; m_drop = !in_last; m_cnt = 0; m_bytes = 0;
      end
      if (take) begin
        if (in_last) begin
          int b;
          b = m_bytes + nb;
          m_hdr = 1;
          m_hw = in_err ? 1 : m_cnt + 2;
          m_hword = in_err ? 32'hC000_0000 : (32'h8000_0000 | (in_oob << 29) | enc_len(b));
          m_cnt = 0; m_bytes = 0;
        end else begin
          m_cnt++; m_bytes += 4;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin m_en = reg_wdata[10]; m_full = 0; m_ready = 0; m_cnt = 0; m_bytes = 0; end
          2'd1: m_waddr = reg_wdata & 32'hFFFC;
          2'd2: m_avail = reg_wdata & 32'hFFFF;
          default: ;
        endcase
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic send_beat(logic [31:0] d, bit last, logic [1:0] nb, bit err, bit oob);
    bit taken;
    in_valid = 1'b1; in_data = d; in_last = last;
    in_nbytes = last ? nb : 2'd0; in_err = last && err; in_oob = last && oob;
    taken = 1'b0;
    while (!taken) begin
      taken = in_ready;
      tick(1);
    end
  endtask

  task automatic send_frame(int nw, logic [1:0] nb, bit err, bit oob, logic [31:0] seed);
    for (int k = 0; k < nw; k++)
      send_beat(seed + 32'(k), k == nw - 1, nb, err, oob);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; in_oob = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w0, i0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 irq_rx", 32'(irq_rx), 0);
    reg_addr = 2'd0; #1 chk("R1 control", reg_rdata, 0);
    reg_addr = 2'd1; #1 chk("R1 address", reg_rdata, 0);

    wr_reg(2'd1, 32'h0000_0102);
    wr_reg(2'd2, 32'd64);
    wr_reg(2'd0, 32'h0000_0400);
    reg_addr = 2'd1;
    tick(1);
    chk("R10 address aligned", reg_rdata, 32'h100);

    // A (3 words, 9 bytes) then B (2 words, trailer) back to back
    send_frame(3, 2'd1, 1'b0, 1'b0, 32'hA000_0000);
    tick(1);
    chk("R4 odd length header", last_hdr, 32'h8000_000B);
    send_frame(2, 2'd0, 1'b0, 1'b1, 32'hB000_0000);
    tick(2);
    chk("R4 trailer header", last_hdr, 32'hA000_0008);
    reg_addr = 2'd1; #1 chk("R5 address after two frames", reg_rdata, 32'h11C);
    reg_addr = 2'd2; #1 chk("R5 budget after two frames", reg_rdata, 32'd57);
    reg_addr = 2'd0; #1 chk("R11 ready set", reg_rdata, 32'h500);

    // C: error frame
    send_frame(4, 2'd0, 1'b1, 1'b0, 32'hC000_0000);
    tick(2);
    chk("R6 error header", last_hdr, 32'hC000_0000);
    reg_addr = 2'd1; #1 chk("R6 address after error", reg_rdata, 32'h120);
    reg_addr = 2'd2; #1 chk("R6 budget after error", reg_rdata, 32'd56);

    // D: short frame
    send_frame(1, 2'd2, 1'b0, 1'b0, 32'hD000_0000);
    tick(2);
    chk("R4 two-byte header", last_hdr, 32'h8000_0002);
    reg_addr = 2'd0;
    wr_reg(2'd0, 32'h0000_0400);
    #1 chk("R9 control write clears ready", reg_rdata, 32'h400);

    // overflow
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h200);
    wr_reg(2'd2, 32'd5);
    wr_reg(2'd0, 32'h400);
    w0 = n_writes; i0 = n_irqs;
    send_frame(6, 2'd0, 1'b0, 1'b0, 32'hE000_0000);
    send_frame(1, 2'd0, 1'b0, 1'b0, 32'hE100_0000);
    tick(2);
    chk("R7 only fitting words written", 32'(n_writes - w0), 4);
    chk("R7 no interrupt", 32'(n_irqs - i0), 0);
    reg_addr = 2'd0; #1 chk("R7 full bit", reg_rdata, 32'h600);
    reg_addr = 2'd1; #1 chk("R7 address unchanged", reg_rdata, 32'h200);

    // exact fit after re-arm
    wr_reg(2'd0, 32'h400);
    send_frame(4, 2'd0, 1'b0, 1'b0, 32'hF000_0000);
    tick(2);
    chk("R4 exact fit header", last_hdr, 32'h8000_0010);
    reg_addr = 2'd2; #1 chk("R5 budget used up", reg_rdata, 0);
    w0 = n_writes;
    send_frame(1, 2'd0, 1'b0, 1'b0, 32'hF100_0000);
    tick(2);
    chk("R7 no room for one word", 32'(n_writes - w0), 0);

    // disabled
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h300);
    wr_reg(2'd2, 32'd32);
    w0 = n_writes; i0 = n_irqs;
    send_frame(2, 2'd0, 1'b0, 1'b0, 32'h1100_0000);
    send_beat(32'h1200_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    in_valid = 1'b0;
    wr_reg(2'd0, 32'h400);
    send_frame(1, 2'd0, 1'b0, 1'b0, 32'h1200_0001);
    tick(2);
    chk("R8 disabled frames dropped", 32'(n_writes - w0), 0);
    chk("R8 no interrupt", 32'(n_irqs - i0), 0);
    send_frame(1, 2'd3, 1'b0, 1'b0, 32'h1300_0000);
    tick(2);
    chk("R4 three-byte header", last_hdr, 32'h8000_0005);
    reg_addr = 2'd1; #1 chk("R10 address after frame", reg_rdata, 32'h308);
    reg_addr = 2'd3; #1 chk("R10 unused register", reg_rdata, 0);
    tick(2);
    finish_run();
  end
endmodule